// File: doc/BRIEF.md
# Serial Character Receiver with Error-Tagged Queue

This block turns an asynchronous serial input line into characters and stores each one in a small first-in first-out queue, together with four bits that describe what went wrong while it was being received. It runs entirely in the system clock domain. A one-cycle oversampling tick, supplied by a separate baud generator at 16 or 8 times the bit rate, paces all line sampling. The line input is expected to be synchronized to the clock already.

Software-side logic or a downstream engine reads the queue through a show-ahead port. The head entry, with its character and status, is always visible while the queue is not empty, and a one-cycle read strobe removes it. The character length, the parity checking and the oversampling ratio are static configuration inputs. They are held steady while a character is on the line.

Top module: `rx_frame_queue`

## Requirements
- R1: After reset `empty_o` is 1 and `full_o` is 0.
- R2: A falling line seen on a tick only starts a character if the line is still low at the mid-start sample, which is tick 8 (16x) or tick 4 (8x) counted from the detecting tick. Otherwise the receiver drops back to idle and stores nothing.
- R3: Data bits arrive least significant bit first. `wlen_i` selects 5, 6, 7 or 8 bits (codes 0, 1, 2, 3). The character is right-aligned in `rd_data_o`, and the unused upper bits read 0.
- R4: With `ovs8_i`=0 a bit lasts 16 ticks, and with `ovs8_i`=1 it lasts 8 ticks. Every bit after the start bit is sampled one full bit period after the previous sample. The entry is stored on the tick that samples the first stop bit.
- R5: With `par_en_i`=1, one parity bit follows the data. With `par_even_i`=1 the data plus parity must hold an even number of ones, and with `par_even_i`=0 an odd number. A mismatch sets `rd_stat_o[1]`. With `par_en_i`=0 no parity bit is expected and `rd_stat_o[1]` is 0.
- R6: `rd_stat_o[0]` (framing) is set when the first stop bit is sampled low. Only one stop bit is checked.
- R7: When the data, parity and stop samples are all low, a single break entry is stored. It carries data 0, `rd_stat_o[2]`=1, `rd_stat_o[0]`=1 and `rd_stat_o[1]`=0. No new character starts until the line has been seen high on a tick.
- R8: The queue holds 16 entries in arrival order. `rd_i` pops the head when the queue is not empty and has no effect when it is empty.
- R9: `full_o` is 1 with 16 entries stored. A character completed while the queue is full is discarded, and the next entry that is stored carries `rd_stat_o[3]`=1 (overrun). Later entries carry 0 in that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Oversampling tick, one cycle wide |
| rxd_i | input | 1 | Serial line, idle high, already synchronized |
| ovs8_i | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| wlen_i | input | 2 | Character length code, 5 + code bits |
| par_en_i | input | 1 | Parity bit expected after the data |
| par_even_i | input | 1 | 1 even parity, 0 odd parity |
| rd_i | input | 1 | Pop the head entry |
| rd_data_o | output | 8 | Head character |
| rd_stat_o | output | 4 | Head status: [3] overrun, [2] break, [1] parity, [0] framing |
| empty_o | output | 1 | Queue holds no entry |
| full_o | output | 1 | Queue holds 16 entries |

## Verification
The assertions assume that the tick is a single-cycle pulse and that the configuration inputs do not change while a character is in flight. This matters because the break property reads the head status, and the store-on-tick property ties queue writes to the tick. The stimulus sends every bit as a whole number of ticks, with one idle cycle between ticks. It changes the configuration only between characters, after at least one bit period of idle-high line, so every character starts from the idle state.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int unsigned DW = 8;

   typedef struct packed {
      logic ovr;
      logic brk;
      logic par;
      logic frm;
   } rx_stat_t;

   typedef struct packed {
      rx_stat_t         st;
      logic [DW-1:0]    data;
   } rx_entry_t;

   typedef enum logic [2:0] {
      S_IDLE,
      S_START,
      S_DATA,
      S_PAR,
      S_STOP,
      S_BRKW
   } rx_state_t;
endpackage

// File: rtl/rxq_deframer.sv
module rxq_deframer
   import rxq_pkg::*;
#(
   parameter int unsigned OVS_HI = 16,
   parameter int unsigned OVS_LO = 8
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      tick_i,
   input  logic      rxd_i,
   input  logic      ovs8_i,
   input  logic [1:0] wlen_i,
   input  logic      par_en_i,
   input  logic      par_even_i,
   input  logic      full_i,
   output logic      push_o,
   output rx_entry_t entry_o
);
   localparam int unsigned CW = $clog2(OVS_HI);

   rx_state_t      st_q;
   logic [CW-1:0]  cnt_q;
   logic [2:0]     bit_q;
   logic [DW-1:0]  sh_q;
   logic           pbit_q;
   logic           seen1_q;
   logic           ovr_pend_q;

   logic [CW-1:0]  lim_bit;
   logic [CW-1:0]  lim_mid;
   logic [2:0]     nbits_m1;
   logic [2:0]     shamt;
   logic [DW-1:0]  data_al;
   logic           brk_now;
   logic           at_lim;

   assign lim_bit  = ovs8_i ? CW'(OVS_LO - 1) : CW'(OVS_HI - 1);
   assign lim_mid  = ovs8_i ? CW'(OVS_LO / 2 - 1) : CW'(OVS_HI / 2 - 1);
   assign at_lim   = (cnt_q == lim_bit);
   assign nbits_m1 = 3'd4 + {1'b0, wlen_i};
   assign shamt    = 3'(DW - 1) - nbits_m1;
   assign data_al  = sh_q >> shamt;
   assign brk_now  = !seen1_q && !rxd_i;

   assign push_o        = tick_i && (st_q == S_STOP) && at_lim;
   assign entry_o.data  = data_al;
   assign entry_o.st.ovr = ovr_pend_q;
   assign entry_o.st.brk = brk_now;
   assign entry_o.st.frm = !rxd_i;
   assign entry_o.st.par = par_en_i && !brk_now && ((^data_al) ^ pbit_q ^ ~par_even_i);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q    <= S_IDLE;
         cnt_q   <= '0;
         bit_q   <= '0;
         sh_q    <= '0;
         pbit_q  <= 1'b0;
         seen1_q <= 1'b0;
      end else if (tick_i) begin
         case (st_q)
            S_IDLE: begin
               if (!rxd_i) begin
                  st_q  <= S_START;
                  cnt_q <= '0;
               end
            end
            S_START: begin
               if (cnt_q == lim_mid) begin
                  cnt_q   <= '0;
                  bit_q   <= '0;
                  seen1_q <= 1'b0;
                  st_q    <= rxd_i ? S_IDLE : S_DATA;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            S_DATA: begin
               if (at_lim) begin
                  cnt_q   <= '0;
                  sh_q    <= {rxd_i, sh_q[DW-1:1]};
                  seen1_q <= seen1_q | rxd_i;
                  bit_q   <= bit_q + 1'b1;
                  if (bit_q == nbits_m1) st_q <= par_en_i ? S_PAR : S_STOP;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            S_PAR: begin
               if (at_lim) begin
                  cnt_q   <= '0;
                  pbit_q  <= rxd_i;
                  seen1_q <= seen1_q | rxd_i;
                  st_q    <= S_STOP;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            S_STOP: begin
               if (at_lim) begin
                  cnt_q <= '0;
                  st_q  <= brk_now ? S_BRKW : S_IDLE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            S_BRKW: begin
               if (rxd_i) st_q <= S_IDLE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     ovr_pend_q <= 1'b0;
      else if (push_o) ovr_pend_q <= full_i;
   end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned W     = 12
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   input  logic         rd_i,
   output logic [W-1:0] rdata_o,
   output logic         empty_o,
   output logic         full_o
);
   localparam int unsigned AW = $clog2(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [AW:0]   cnt_q;
   logic          wr_ok, rd_ok;

   assign empty_o = (cnt_q == '0);
   assign full_o  = (cnt_q == (AW+1)'(DEPTH));
   assign wr_ok   = wr_i && !full_o;
   assign rd_ok   = rd_i && !empty_o;
   assign rdata_o = mem[rp_q];

   always_ff @(posedge clk_i) begin
      if (wr_ok) mem[wp_q] <= wdata_i;
   end

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               wp_q <= '0;
               rp_q <= '0;
            end else begin
               if (wr_ok) wp_q <= wp_q + 1'b1;
               if (rd_ok) rp_q <= rp_q + 1'b1;
            end
         end
      end else begin : g_wrap
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               wp_q <= '0;
               rp_q <= '0;
            end else begin
               if (wr_ok) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
               if (rd_ok) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) cnt_q <= '0;
      else begin
         case ({wr_ok, rd_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/rx_frame_queue.sv
module rx_frame_queue
   import rxq_pkg::*;
#(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned OVS_HI = 16,
   parameter int unsigned OVS_LO = 8
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       tick_i,
   input  logic       rxd_i,
   input  logic       ovs8_i,
   input  logic [1:0] wlen_i,
   input  logic       par_en_i,
   input  logic       par_even_i,
   input  logic       rd_i,
   output logic [7:0] rd_data_o,
   output logic [3:0] rd_stat_o,
   output logic       empty_o,
   output logic       full_o
);
   localparam int unsigned EW = $bits(rx_entry_t);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rx_frame_queue: DEPTH must be at least 2");
      end
      if (OVS_LO < 2 || (OVS_LO % 2) != 0 || OVS_HI <= OVS_LO || (OVS_HI % 2) != 0) begin : g_bad_ovs
         $error("rx_frame_queue: oversampling ratios must be even with OVS_HI > OVS_LO >= 2");
      end
      if (DW != 8) begin : g_bad_dw
         $error("rx_frame_queue: character field must be 8 bits wide");
      end
   endgenerate

   logic      df_push;
   rx_entry_t df_entry;
   rx_entry_t head;

   rxq_deframer #(
      .OVS_HI (OVS_HI),
      .OVS_LO (OVS_LO)
   ) u_deframer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .rxd_i      (rxd_i),
      .ovs8_i     (ovs8_i),
      .wlen_i     (wlen_i),
      .par_en_i   (par_en_i),
      .par_even_i (par_even_i),
      .full_i     (full_o),
      .push_o     (df_push),
      .entry_o    (df_entry)
   );

   rxq_fifo #(
      .DEPTH (DEPTH),
      .W     (EW)
   ) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (df_push),
      .wdata_i (df_entry),
      .rd_i    (rd_i),
      .rdata_o (head),
      .empty_o (empty_o),
      .full_o  (full_o)
   );

   assign rd_data_o = head.data;
   assign rd_stat_o = head.st;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       tick_i,
   input logic       rd_i,
   input logic       df_push,
   input logic [7:0] rd_data_o,
   input logic [3:0] rd_stat_o,
   input logic       empty_o,
   input logic       full_o
);
   AST_NOT_EMPTY_AND_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(empty_o && full_o)); // R8

   AST_EMPTY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      empty_o && !df_push |=> empty_o); // R8

   AST_PUSH_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      df_push && !full_o |=> !empty_o); // R8

   AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      full_o && !rd_i |=> full_o); // R9

   AST_PUSH_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      df_push |-> tick_i); // R4

   AST_BREAK_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !empty_o && rd_stat_o[2] |-> (rd_data_o == 8'h00) && rd_stat_o[0] && !rd_stat_o[1]); // R7
endmodule

bind rx_frame_queue rxq_checker u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .tick_i    (tick_i),
   .rd_i      (rd_i),
   .df_push   (df_push),
   .rd_data_o (rd_data_o),
   .rd_stat_o (rd_stat_o),
   .empty_o   (empty_o),
   .full_o    (full_o)
);

// File: tb/rx_frame_queue_bench.sv
`timescale 1ns/1ps
module rx_frame_queue_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       rxd = 1'b1;
   logic       ovs8 = 1'b0;
   logic [1:0] wlen = 2'd3;
   logic       pen = 1'b0;
   logic       peven = 1'b1;
   logic       rd = 1'b0;
   logic [7:0] rd_data;
   logic [3:0] rd_stat;
   logic       empty, full;

   int    n_chk = 0;
   int    n_err = 0;
   bit    run_cmp = 1'b0;
   bit    done = 1'b0;
   string cur_req = "R1";
   logic [11:0] exp_q[$];
   logic  ovr_pend = 1'b0;

   always #4 clk = ~clk;

   rx_frame_queue u_rx_frame_queue (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .tick_i     (tick),
      .rxd_i      (rxd),
      .ovs8_i     (ovs8),
      .wlen_i     (wlen),
      .par_en_i   (pen),
      .par_even_i (peven),
      .rd_i       (rd),
      .rd_data_o  (rd_data),
      .rd_stat_o  (rd_stat),
      .empty_o    (empty),
      .full_o     (full)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, expv, $time);
      end
   endtask

   // reference queue update for one completed character (overrun rule of R9)
   function automatic void model_push(input logic [11:0] e);
      logic [11:0] t;
      t = e;
      if (exp_q.size() == 16) begin
         ovr_pend = 1'b1;
      end else begin
         t[11] = ovr_pend;
         ovr_pend = 1'b0;
         exp_q.push_back(t);
      end
   endfunction

   // compare against the reference every cycle, away from the clock edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (run_cmp) begin
            chk(empty == (exp_q.size() == 0), cur_req, "empty", int'(empty), int'(exp_q.size() == 0));
            chk(full == (exp_q.size() == 16), cur_req, "full", int'(full), int'(exp_q.size() == 16));
            if (exp_q.size() != 0 && !empty) begin
               chk(rd_data == exp_q[0][7:0], cur_req, "head data", int'(rd_data), int'(exp_q[0][7:0]));
               chk(rd_stat == exp_q[0][11:8], cur_req, "head status", int'(rd_stat), int'(exp_q[0][11:8]));
            end
         end
      end
   end

   task automatic do_tick();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic pop();
      @(negedge clk);
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      if (exp_q.size() != 0) void'(exp_q.pop_front());
   endtask

   task automatic drain();
      while (exp_q.size() != 0) pop();
   endtask

   task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic stop_v);
      int          nov;
      int          nb;
      int          tot;
      logic [7:0]  dm;
      logic        pb;
      logic        allz;
      logic [11:0] bits;
      logic [11:0] e;
      nov = ovs8 ? 8 : 16;
      nb  = 5 + int'(wlen);
      dm  = d & 8'((9'd1 << nb) - 9'd1);
      pb  = (^dm) ^ !peven ^ bad_par;
      bits = '0;
      for (int i = 0; i < nb; i++) bits[1+i] = dm[i];
      tot = 1 + nb;
      if (pen) begin
         bits[tot] = pb;
         tot++;
      end
      bits[tot] = stop_v;
      tot++;
      allz = (dm == 8'h00) && !(pen && pb) && !stop_v;
      e = {1'b0, allz, pen && bad_par && !allz, !stop_v, dm};
      for (int j = 0; j < tot; j++) begin
         rxd = bits[j];
         for (int k = 0; k < nov; k++) begin
            do_tick();
            if (j == tot - 1 && k == nov / 2) model_push(e);
         end
      end
      if (allz) begin
         rxd = 1'b0;
         repeat (2 * nov) do_tick();
      end
      rxd = 1'b1;
      repeat (nov) do_tick();
   endtask

   task automatic glitch(input int low_ticks);
      int nov;
      nov = ovs8 ? 8 : 16;
      rxd = 1'b0;
      repeat (low_ticks) do_tick();
      rxd = 1'b1;
      repeat (2 * nov) do_tick();
   endtask

   initial begin
      #1200000;
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(empty == 1'b1, "R1", "empty in reset", int'(empty), 1);
      chk(full == 1'b0, "R1", "full in reset", int'(full), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(empty == 1'b1, "R1", "empty after reset", int'(empty), 1);
      chk(full == 1'b0, "R1", "full after reset", int'(full), 0);
      @(negedge clk);
      run_cmp = 1'b1;

      // R3/R4: 16x, 8 data bits, no parity
      cur_req = "R3";
      send_frame(8'hA5, 1'b0, 1'b1);
      send_frame(8'h3C, 1'b0, 1'b1);
      chk(exp_q.size() == 2, "R3", "model depth", exp_q.size(), 2);
      drain();

      // R3: shorter characters, upper bits zero
      wlen = 2'd0; send_frame(8'hFF, 1'b0, 1'b1);
      wlen = 2'd1; send_frame(8'hEA, 1'b0, 1'b1);
      wlen = 2'd2; send_frame(8'h81, 1'b0, 1'b1);
      drain();
      wlen = 2'd3;

      // R4: 8x oversampling
      cur_req = "R4";
      ovs8 = 1'b1;
      send_frame(8'h5A, 1'b0, 1'b1);
      send_frame(8'h01, 1'b0, 1'b1);
      wlen = 2'd1; send_frame(8'h2D, 1'b0, 1'b1);
      drain();
      wlen = 2'd3;
      ovs8 = 1'b0;

      // R5: parity good and bad, both senses
      cur_req = "R5";
      pen = 1'b1;
      peven = 1'b1; send_frame(8'h37, 1'b0, 1'b1); send_frame(8'h37, 1'b1, 1'b1);
      peven = 1'b0; send_frame(8'hC4, 1'b0, 1'b1); send_frame(8'hC4, 1'b1, 1'b1);
      drain();
      pen = 1'b0;

      // R6: stop bit low
      cur_req = "R6";
      send_frame(8'h55, 1'b0, 1'b0);
      ovs8 = 1'b1; send_frame(8'h80, 1'b0, 1'b0); ovs8 = 1'b0;
      drain();

      // R2: short start pulses store nothing, then a real character
      cur_req = "R2";
      glitch(8);
      glitch(1);
      ovs8 = 1'b1; glitch(4); ovs8 = 1'b0;
      chk(exp_q.size() == 0 && empty, "R2", "empty after glitches", int'(empty), 1);
      send_frame(8'h9E, 1'b0, 1'b1);
      drain();

      // R7: break, one entry, then normal reception
      cur_req = "R7";
      pen = 1'b1; peven = 1'b1;
      send_frame(8'h00, 1'b0, 1'b0);
      chk(exp_q.size() == 1, "R7", "break entries", exp_q.size(), 1);
      send_frame(8'h42, 1'b0, 1'b1);
      pen = 1'b0;
      ovs8 = 1'b1; send_frame(8'h00, 1'b0, 1'b0); ovs8 = 1'b0;
      drain();

      // R8: read on empty has no effect, order is kept
      cur_req = "R8";
      pop(); pop();
      ovs8 = 1'b1;
      send_frame(8'h11, 1'b0, 1'b1);
      send_frame(8'h22, 1'b0, 1'b1);
      send_frame(8'h33, 1'b0, 1'b1);
      drain();
      pop();

      // R9: fill, overflow, overrun flag on next stored entry
      cur_req = "R9";
      for (int n = 0; n < 16; n++) send_frame(8'(n * 7 + 3), 1'b0, 1'b1);
      chk(full == 1'b1, "R9", "full at 16", int'(full), 1);
      send_frame(8'hEE, 1'b0, 1'b1);
      send_frame(8'hDD, 1'b0, 1'b1);
      pop();
      send_frame(8'h6B, 1'b0, 1'b1);
      send_frame(8'h6C, 1'b0, 1'b1);
      drain();

      run_cmp = 1'b0;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule